// File: doc/BRIEF.md
# Ripple Marker FIFO

This block is a sixteen-entry, four-bit first-in-first-out buffer with no read or write pointers. It is a chain of stages, and each stage carries a word together with a one-bit occupancy marker. A stage that is empty copies the word from a full stage just upstream of it, and that upstream stage empties in the same clock. Words therefore fall through toward the output end one stage per clock, and vacancies drift back toward the input end. The input-ready flag is the inverse of the input stage's marker. The output-ready flag is the output stage's marker.

A producer raises `push_strobe` while `in_ready` is high and lowers it again before the next word. A consumer reads `dout` while `out_ready` is high, then raises `pop_strobe` to discard that word. Both strobes are sampled in the system clock domain. A small two-state machine on each strobe turns a rising level into a single event.

Each stage is a machine with two states. SLOT_EMPTY moves to SLOT_FULL on the fill transition, which happens when the upstream stage is full, or on an accepted push for the input stage. SLOT_FULL moves to SLOT_EMPTY on the drain transition, which happens when the downstream stage is empty, or on an accepted pop for the output stage. Each strobe machine also has two states. STB_WAIT_LOW moves to STB_ARMED on the arm transition, when the strobe is seen low. STB_ARMED moves to STB_WAIT_LOW on the fire transition, when the strobe is seen high. The fire transition yields an event only if the matching ready flag is high. Master reset puts every stage in SLOT_EMPTY and every strobe machine in STB_WAIT_LOW.

Top module: `ripple_fifo`

## Requirements
- R1: While `mreset` is high, and after it falls, every stored word is discarded. `in_ready` reads 1, `out_ready` reads 0 and `dout` reads 4'h0 with `oe` high. No word held before the reset ever reaches the output.
- R2: Words leave in the order they entered, and up to 16 words can be held at once.
- R3: A word is entered only on a clock where `push_strobe` is high after having been seen low. A strobe held high for many clocks enters exactly one word. A strobe already high when reset is released enters nothing until it has been seen low.
- R4: With 16 words held, `in_ready` stays 0. Push strobes given while `in_ready` is 0 enter no word.
- R5: `out_ready` is 1 exactly when the output stage holds a word. A word pushed into an empty buffer moves one stage per clock. `out_ready` is still 0 after the 14th clock edge that follows the accepting edge and is 1 after the 15th.
- R6: After an accepted push with the second stage empty, `in_ready` is 0 for exactly one clock and then returns to 1.
- R7: While `out_ready` and `oe` are both 1, `dout` shows the oldest stored word.
- R8: A `pop_strobe` rising level while `out_ready` is 1 removes the shown word, and `out_ready` reads 0 right after that edge. When the next word is waiting in the neighbouring stage, `out_ready` returns to 1 one clock later. A pop while `out_ready` is 0 removes nothing.
- R9: While `oe` is 0, `dout` is high-impedance and does not show the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mreset | input | 1 | Master reset, active high, asynchronous |
| push_strobe | input | 1 | Enters `din` on its rising level |
| din | input | 4 | Word to enter |
| in_ready | output | 1 | Input stage is empty |
| pop_strobe | input | 1 | Removes the output word on its rising level |
| oe | input | 1 | Output enable for `dout` |
| dout | output | 4 | Output stage word, or high-impedance |
| out_ready | output | 1 | Output stage holds a word |

## Verification
An accepted push lands in the input stage on the same edge that samples the strobe. `in_ready` is low at the following falling edge and high one falling edge later. `out_ready` rises after the 15th edge past the accepting edge. A pop clears `out_ready` on its own edge, and a waiting word refills the output one edge later. The bench drives strobes and samples flags on falling edges, and it counts those edges exactly to the cycle each result is due. Where only the final content matters, it waits a fixed settling window before it checks.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

    // Occupancy of one word stage.
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    // Level tracker that turns a strobe into a single event.
    typedef enum logic {
        STB_WAIT_LOW = 1'b0,
        STB_ARMED    = 1'b1
    } strobe_state_e;

endpackage

// File: rtl/rf_strobe_fsm.sv
module rf_strobe_fsm
    import ripple_fifo_pkg::*;
(
    input  logic clk,
    input  logic mreset,
    input  logic level,
    input  logic enable,
    output logic fire
);

    strobe_state_e state_q;
    strobe_state_e state_d;

    // State register. After reset the strobe must be seen low first.
    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) begin
            state_q <= STB_WAIT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: arm on a low level, consume the event on a high level.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STB_WAIT_LOW: if (!level) state_d = STB_ARMED;
            STB_ARMED:    if (level)  state_d = STB_WAIT_LOW;
        endcase
    end

    // Output: an event counts only when the matching side is ready.
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            STB_WAIT_LOW: fire = 1'b0;
            STB_ARMED:    fire = level && enable;
        endcase
    end

endmodule

// File: rtl/rf_stage.sv
module rf_stage
    import ripple_fifo_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             fill_req,
    input  logic [WIDTH-1:0] fill_data,
    input  logic             drain_req,
    output logic             full,
    output logic [WIDTH-1:0] data
);

    slot_state_e      state_q;
    slot_state_e      state_d;
    logic             load;
    logic [WIDTH-1:0] data_q;

    // State register.
    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: fill when empty and offered a word, drain when full and released.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (fill_req) begin
                    state_d = SLOT_FULL;
                    load    = 1'b1;
                end
            end
            SLOT_FULL: begin
                if (drain_req) state_d = SLOT_EMPTY;
            end
        endcase
    end

    // Word register, written only on the fill transition.
    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= fill_data;
        end
    end

    // Outputs.
    always_comb begin
        full = (state_q == SLOT_FULL);
        data = data_q;
    end

endmodule

// File: rtl/rf_tristate_out.sv
module rf_tristate_out #(
    parameter int WIDTH = 4
) (
    input  logic             oe,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] pins
);

    assign pins = oe ? word : {WIDTH{1'bz}};

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             push_strobe,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             pop_strobe,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             out_ready
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] marks;
    logic [WIDTH-1:0] words [DEPTH];
    logic             push_fire;
    logic             pop_fire;

    assign in_ready  = !marks[0];
    assign out_ready = marks[LAST];

    rf_strobe_fsm u_push_edge (
        .clk    (clk),
        .mreset (mreset),
        .level  (push_strobe),
        .enable (in_ready),
        .fire   (push_fire)
    );

    rf_strobe_fsm u_pop_edge (
        .clk    (clk),
        .mreset (mreset),
        .level  (pop_strobe),
        .enable (out_ready),
        .fire   (pop_fire)
    );

    // Stage chain: stage 0 is the input end, stage LAST the output end.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic             fill_req;
        logic [WIDTH-1:0] fill_data;
        logic             drain_req;

        if (g == 0) begin : g_head
            assign fill_req  = push_fire;
            assign fill_data = din;
            assign drain_req = !marks[g+1];
        end else if (g == LAST) begin : g_tail
            assign fill_req  = marks[g-1];
            assign fill_data = words[g-1];
            assign drain_req = pop_fire;
        end else begin : g_mid
            assign fill_req  = marks[g-1];
            assign fill_data = words[g-1];
            assign drain_req = !marks[g+1];
        end

        rf_stage #(.WIDTH(WIDTH)) u_stage (
            .clk       (clk),
            .mreset    (mreset),
            .fill_req  (fill_req),
            .fill_data (fill_data),
            .drain_req (drain_req),
            .full      (marks[g]),
            .data      (words[g])
        );
    end

    rf_tristate_out #(.WIDTH(WIDTH)) u_out (
        .oe   (oe),
        .word (words[LAST]),
        .pins (dout)
    );

endmodule

// File: rtl/ripple_fifo_checker.sv
module ripple_fifo_checker #(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             mreset,
    input logic             push_strobe,
    input logic             pop_strobe,
    input logic             in_ready,
    input logic             out_ready,
    input logic [DEPTH-1:0] marks
);

    // R2: the stored count moves by at most one per clock.
    a_r2_count_step: assert property (@(posedge clk) disable iff (mreset)
        1'b1 |=> (($countones(marks) <= $past($countones(marks)) + 1) &&
                  ($countones(marks) + 1 >= $past($countones(marks)))));

    // R3: a strobe that was already high enters no new word.
    a_r3_level_no_entry: assert property (@(posedge clk) disable iff (mreset)
        (push_strobe && $past(push_strobe)) |=> ($countones(marks) <= $past($countones(marks))));

    // R4: nothing enters while the input stage is occupied.
    a_r4_no_entry_busy: assert property (@(posedge clk) disable iff (mreset)
        !in_ready |=> ($countones(marks) <= $past($countones(marks))));

    // R5: the output word stays available until a pop is given.
    a_r5_out_hold: assert property (@(posedge clk) disable iff (mreset)
        (out_ready && !pop_strobe) |=> out_ready);

    // R8: a pop with nothing shown removes nothing.
    a_r8_no_loss_empty: assert property (@(posedge clk) disable iff (mreset)
        !out_ready |=> ($countones(marks) >= $past($countones(marks))));

endmodule

bind ripple_fifo ripple_fifo_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .mreset      (mreset),
    .push_strobe (push_strobe),
    .pop_strobe  (pop_strobe),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .marks       (marks)
);

// File: tb/sim_ripple_fifo.sv
`timescale 1ns/1ps
module sim_ripple_fifo;

    logic       clk = 1'b0;
    logic       mreset;
    logic       push_strobe;
    logic       pop_strobe;
    logic       oe;
    logic [3:0] din;
    wire  [3:0] dout;
    logic       in_ready;
    logic       out_ready;

    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;
    logic [3:0] model [$];

    always #4 clk = ~clk;

    ripple_fifo u0 (
        .clk         (clk),
        .mreset      (mreset),
        .push_strobe (push_strobe),
        .din         (din),
        .in_ready    (in_ready),
        .pop_strobe  (pop_strobe),
        .oe          (oe),
        .dout        (dout),
        .out_ready   (out_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        mreset = 1'b1;
        @(negedge clk);
        mreset = 1'b0;
        model.delete();
    endtask

    task automatic push_word(input logic [3:0] v);
        int t = 0;
        @(negedge clk);
        while (!in_ready && t < 100) begin
            @(negedge clk);
            t++;
        end
        din = v;
        push_strobe = 1'b1;
        @(negedge clk);
        push_strobe = 1'b0;
        model.push_back(v);
    endtask

    task automatic pop_word(input string req, input bit expect_next);
        int t = 0;
        logic [3:0] exp;
        while (!out_ready && t < 100) begin
            @(negedge clk);
            t++;
        end
        exp = (model.size() > 0) ? model.pop_front() : 4'h0;
        chk({req, " oldest word"}, dout, exp);
        pop_strobe = 1'b1;
        @(negedge clk);
        pop_strobe = 1'b0;
        chk("R8 out_ready low after pop", out_ready, 1'b0);
        if (expect_next) begin
            @(negedge clk);
            chk("R8 next word one clock later", out_ready, 1'b1);
        end
    endtask

    task automatic drain_all(input string req, input bit packed_q);
        while (model.size() > 0) pop_word(req, packed_q && model.size() > 1);
        repeat (20) @(negedge clk);
        chk({req, " empty after drain"}, out_ready, 1'b0);
    endtask

    task automatic t_reset();
        mreset = 1'b1;
        repeat (3) @(negedge clk);
        mreset = 1'b0;
        @(negedge clk);
        chk("R1 in_ready after reset", in_ready, 1'b1);
        chk("R1 out_ready after reset", out_ready, 1'b0);
        chk("R1 dout after reset", dout, 4'h0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        din = 4'hA;
        push_strobe = 1'b1;
        @(negedge clk);
        push_strobe = 1'b0;
        chk("R6 in_ready low after accept", in_ready, 1'b0);
        @(negedge clk);
        chk("R6 in_ready back high", in_ready, 1'b1);
        repeat (13) @(negedge clk);
        chk("R5 out_ready low after 14 edges", out_ready, 1'b0);
        @(negedge clk);
        chk("R5 out_ready high after 15 edges", out_ready, 1'b1);
        chk("R7 dout after fall-through", dout, 4'hA);
        model.push_back(4'hA);
        pop_word("R7", 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 empty after single pop", out_ready, 1'b0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) push_word(4'((i * 5 + 1) & 15));
        repeat (20) @(negedge clk);
        chk("R4 in_ready low when full", in_ready, 1'b0);
        chk("R2 out_ready when full", out_ready, 1'b1);
        din = 4'hF;
        push_strobe = 1'b1;
        @(negedge clk);
        push_strobe = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 still full after ignored push", in_ready, 1'b0);
        drain_all("R2 R4 full drain", 1'b1);
    endtask

    task automatic t_hold_high();
        @(negedge clk);
        din = 4'h6;
        push_strobe = 1'b1;
        repeat (30) @(negedge clk);
        push_strobe = 1'b0;
        model.push_back(4'h6);
        drain_all("R3 held strobe", 1'b0);
    endtask

    task automatic t_empty_pop();
        @(negedge clk);
        pop_strobe = 1'b1;
        @(negedge clk);
        pop_strobe = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 pop on empty", out_ready, 1'b0);
        push_word(4'h9);
        repeat (20) @(negedge clk);
        chk("R8 word kept after empty pop", out_ready, 1'b1);
        chk("R7 word after empty pop", dout, 4'h9);
        drain_all("R8", 1'b0);
    endtask

    task automatic t_oe();
        push_word(4'hA);
        repeat (20) @(negedge clk);
        oe = 1'b0;
        #1;
        chk("R9 dout hidden when disabled", 32'(dout !== 4'hA), 1);
        @(negedge clk);
        oe = 1'b1;
        #1;
        chk("R7 dout shown when enabled", dout, 4'hA);
        drain_all("R9", 1'b0);
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 8; i++) push_word(4'((i * 3 + 2) & 15));
        for (int i = 0; i < 3; i++) pop_word("R2 mixed", 1'b0);
        for (int i = 0; i < 4; i++) push_word(4'((i * 7 + 4) & 15));
        drain_all("R2 mixed", 1'b0);
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 5; i++) push_word(4'(i + 11));
        repeat (3) @(negedge clk);
        do_reset();
        chk("R1 in_ready after mid reset", in_ready, 1'b1);
        chk("R1 out_ready after mid reset", out_ready, 1'b0);
        chk("R1 dout after mid reset", dout, 4'h0);
        push_word(4'h3);
        drain_all("R1 no stale words", 1'b0);
    endtask

    task automatic t_reset_held();
        @(negedge clk);
        push_strobe = 1'b1;
        mreset = 1'b1;
        @(negedge clk);
        mreset = 1'b0;
        repeat (20) @(negedge clk);
        chk("R3 strobe held through reset", out_ready, 1'b0);
        push_strobe = 1'b0;
        model.delete();
        push_word(4'h5);
        drain_all("R3 after reset release", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        mreset = 1'b1;
        push_strobe = 1'b0;
        pop_strobe = 1'b0;
        oe = 1'b1;
        din = 4'h0;
        t_reset();
        t_latency();
        t_full();
        t_hold_high();
        t_empty_pop();
        t_oe();
        t_mixed();
        t_mid_reset();
        t_reset_held();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule